// File: doc/BRIEF.md
# Flag-Generating Arithmetic Logic Unit

This block is the 16-bit arithmetic and logic stage of a small processor datapath. It takes two operands, a three-bit operation code and a byte/word select, and computes a result and a full set of condition flags. The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare. When the enable input is high, the result and the flags are captured on the rising clock edge. The carry-in for the carry and borrow forms comes from the carry flag already held in the status word.

The status word is 16 bits wide. It packs six condition flags (sign, zero, parity, carry, nibble carry and signed overflow) with three control flags (direction, interrupt enable and single-step trap). The control flags have their own set and clear strobes, and arithmetic never changes them. Byte mode works on the low eight bits. The upper byte of the first operand goes through to the result unchanged.

Top module: `flag_alu`

## Requirements
- R1: An active-low reset clears the result register and the whole status word to 0x0000.
- R2: Opcode 0 (add) gives a+b. Opcode 1 (add with carry) gives a+b+CF. CF is set when there is a carry out of the MSB.
- R3: Opcode 2 (subtract) gives a-b. Opcode 3 (subtract with borrow) gives a-b-CF. CF is set when the subtraction needs a borrow.
- R4: Opcodes 4, 5 and 6 give AND, OR and XOR. After any of them, CF (bit 0), AF (bit 4) and OF (bit 11) read 0.
- R5: SF (bit 7) equals the MSB of the result. ZF (bit 6) is 1 exactly when the result is zero.
- R6: PF (bit 2) is 1 when the low eight result bits hold an even number of ones. The upper byte does not affect PF in word mode.
- R7: AF (bit 4) is set by a carry out of bit 3 on addition, or by a borrow into bit 3 on subtraction.
- R8: OF (bit 11) is set when the carry (or borrow) into the MSB differs from the carry (or borrow) out of the MSB.
- R9: When byte_mode is 1, bit 7 is the MSB and the carry is taken out of bit 7. ZF looks only at the low byte. Result bits 15:8 equal a[15:8].
- R10: Opcode 7 (compare) sets the flags exactly as subtract does and leaves the result register unchanged.
- R11: While en is 0, the result and the six condition flags hold their values.
- R12: Control flags TF (bit 8), IF (bit 9) and DF (bit 10) are indexed 0, 1, 2 in ctl_set and ctl_clr. A set strobe wins over a clear strobe on the same bit. Arithmetic operations leave these flags unchanged.
- R13: Status bits 15:12, 5, 3 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture result and condition flags this cycle |
| op | input | 3 | Operation code (0 add, 1 adc, 2 sub, 3 sbb, 4 and, 5 or, 6 xor, 7 cmp) |
| byte_mode | input | 1 | 1 selects 8-bit operation on the low byte |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| ctl_set | input | 3 | Set strobes for TF, IF, DF |
| ctl_clr | input | 3 | Clear strobes for TF, IF, DF |
| result | output | 16 | Registered result |
| status | output | 16 | Registered status word |

## Verification
The hardest case to reach from the ports is the carry and borrow chaining. Add-with-carry and subtract-with-borrow read a CF left by an earlier operation, so the outcome depends on the history of the stream. The stimulus table is therefore ordered so that each chained operation follows one that leaves a known CF, in both word and byte modes. A second hard case is a byte result that is zero while the upper byte is not; the vectors cover it, along with sign and overflow crossings at bit 7 and at bit 15.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_CMP = 3'd7
    } alu_op_e;

    localparam int STAT_W = 16;
    localparam int CTL_N  = 3;

    localparam int FB_CF = 0;
    localparam int FB_PF = 2;
    localparam int FB_AF = 4;
    localparam int FB_ZF = 6;
    localparam int FB_SF = 7;
    localparam int FB_TF = 8;
    localparam int FB_OF = 11;

    localparam logic [STAT_W-1:0] UNUSED_MASK = 16'hF02A;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } cond_t;

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    input  logic              use_cin,
    input  logic              cf_in,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] sum,
    output logic              nib_carry,
    output logic              msb_cin,
    output logic              msb_cout
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] bx;
    logic [DATA_W:0]   c;

    assign bx   = is_sub ? ~b : b;
    assign c[0] = is_sub ? ~(use_cin & cf_in) : (use_cin & cf_in);

    for (genvar i = 0; i < DATA_W; i++) begin : g_ripple
        assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
    end

    assign sum       = a ^ bx ^ c[DATA_W-1:0];
    assign nib_carry = c[NIB_W];
    assign msb_cin   = byte_mode ? c[LANE_W-1] : c[DATA_W-1];
    assign msb_cout  = byte_mode ? c[LANE_W]   : c[DATA_W];
endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] res,
    input  logic              nib_carry,
    input  logic              msb_cin,
    input  logic              msb_cout,
    input  logic              is_sub,
    input  logic              is_logic,
    input  logic              byte_mode,
    output cond_t             cond
);
    localparam int LANE_W = DATA_W / 2;

    always_comb begin
        cond.sf = byte_mode ? res[LANE_W-1] : res[DATA_W-1];
        cond.zf = byte_mode ? (res[LANE_W-1:0] == '0) : (res == '0);
        cond.pf = ~(^res[7:0]);
        if (is_logic) begin
            cond.cf = 1'b0;
            cond.af = 1'b0;
            cond.of = 1'b0;
        end else begin
            cond.cf = msb_cout ^ is_sub;
            cond.af = nib_carry ^ is_sub;
            cond.of = msb_cin ^ msb_cout;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [CTL_N-1:0]  ctl_set,
    input  logic [CTL_N-1:0]  ctl_clr,
    output logic [DATA_W-1:0] result,
    output logic [STAT_W-1:0] status
);
    localparam int LANE_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        cond_t             cond;
        logic [CTL_N-1:0]  ctl;
    } state_t;

    state_t  st_d, st_q;
    alu_op_e op_e;
    logic    is_sub, use_cin, is_logic;
    logic [DATA_W-1:0] sum, logic_res, raw_res, res_sel;
    logic    nib_carry, msb_cin, msb_cout;
    cond_t   cond_n;

    assign op_e     = alu_op_e'(op);
    assign is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
    assign use_cin  = (op_e == OP_ADC) || (op_e == OP_SBB);
    assign is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);

    flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a         (a),
        .b         (b),
        .is_sub    (is_sub),
        .use_cin   (use_cin),
        .cf_in     (st_q.cond.cf),
        .byte_mode (byte_mode),
        .sum       (sum),
        .nib_carry (nib_carry),
        .msb_cin   (msb_cin),
        .msb_cout  (msb_cout)
    );

    always_comb begin
        case (op_e)
            OP_AND:  logic_res = a & b;
            OP_OR:   logic_res = a | b;
            default: logic_res = a ^ b;
        endcase
        raw_res = is_logic ? logic_res : sum;
        res_sel = byte_mode ? {a[DATA_W-1:LANE_W], raw_res[LANE_W-1:0]} : raw_res;
    end

    flag_alu_cond #(.DATA_W(DATA_W)) u_cond (
        .res       (res_sel),
        .nib_carry (nib_carry),
        .msb_cin   (msb_cin),
        .msb_cout  (msb_cout),
        .is_sub    (is_sub),
        .is_logic  (is_logic),
        .byte_mode (byte_mode),
        .cond      (cond_n)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (op_e != OP_CMP) begin
                st_d.result = res_sel;
            end
            st_d.cond = cond_n;
        end
        for (int i = 0; i < CTL_N; i++) begin
            if (ctl_set[i]) begin
                st_d.ctl[i] = 1'b1;
            end else if (ctl_clr[i]) begin
                st_d.ctl[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign status = {4'b0000, st_q.cond.of, st_q.ctl, st_q.cond.sf, st_q.cond.zf,
                     1'b0, st_q.cond.af, 1'b0, st_q.cond.pf, 1'b0, st_q.cond.cf};

    // R13: reserved status positions stay clear
    p_unused_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (status & UNUSED_MASK) == '0);

    // R11: an idle cycle keeps result and condition flags
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(result) && $stable(status[FB_OF]) && $stable(status[FB_SF:FB_ZF])
                 && $stable(status[FB_AF]) && $stable(status[FB_PF]) && $stable(status[FB_CF])));

    // R10: compare never writes the result register
    p_cmp_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd7) |=> $stable(result));

    // R4: logic operations leave carry, nibble carry and overflow clear
    p_logic_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (op == 3'd4 || op == 3'd5 || op == 3'd6)) |=>
        (status[FB_CF] == 1'b0 && status[FB_AF] == 1'b0 && status[FB_OF] == 1'b0));

    // R9: byte mode passes the upper byte of a
    p_upper_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && byte_mode && op != 3'd7) |=> result[DATA_W-1:LANE_W] == $past(a[DATA_W-1:LANE_W]));

    // R12: control flags move only on their strobes, set wins
    p_ctl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set == '0 && ctl_clr == '0) |=> $stable(status[FB_TF+CTL_N-1:FB_TF]));
    p_ctl_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_set[0] && ctl_clr[0]) |=> status[FB_TF]);
endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
    localparam int CLK_NS = 20;
    localparam int NV     = 18;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic        bm;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] res;
        logic [15:0] st;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{4'd2,  3'd0, 1'b0, 16'h1234, 16'h4321, 16'h5555, 16'h0004}, // R2 plain add
        '{4'd2,  3'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 16'h0055}, // R2 carry out, ZF
        '{4'd2,  3'd1, 1'b0, 16'h0001, 16'h0001, 16'h0003, 16'h0004}, // R2 adc with CF=1
        '{4'd8,  3'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 16'h0894}, // R8 positive overflow
        '{4'd3,  3'd2, 1'b0, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095}, // R3 borrow
        '{4'd3,  3'd3, 1'b0, 16'h0005, 16'h0002, 16'h0002, 16'h0000}, // R3 sbb with CF=1
        '{4'd8,  3'd2, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 16'h0814}, // R8 negative overflow
        '{4'd4,  3'd4, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0004}, // R4 and clears AF/OF
        '{4'd5,  3'd5, 1'b0, 16'h8000, 16'h0001, 16'h8001, 16'h0080}, // R5 sign
        '{4'd5,  3'd6, 1'b0, 16'hA5A5, 16'hA5A5, 16'h0000, 16'h0044}, // R5 zero
        '{4'd9,  3'd0, 1'b1, 16'hAB7F, 16'h0001, 16'hAB80, 16'h0890}, // R9 byte overflow at bit 7
        '{4'd9,  3'd0, 1'b1, 16'h12FF, 16'h3401, 16'h1200, 16'h0055}, // R9 byte zero, upper nonzero
        '{4'd7,  3'd2, 1'b1, 16'h5600, 16'h0001, 16'h56FF, 16'h0095}, // R7 nibble borrow
        '{4'd10, 3'd7, 1'b0, 16'h0003, 16'h0003, 16'h56FF, 16'h0044}, // R10 cmp equal
        '{4'd10, 3'd7, 1'b0, 16'h0001, 16'h0002, 16'h56FF, 16'h0095}, // R10 cmp less
        '{4'd7,  3'd3, 1'b1, 16'hEE10, 16'h0F0F, 16'hEE00, 16'h0054}, // R7 byte sbb nibble borrow
        '{4'd9,  3'd1, 1'b1, 16'h0080, 16'h0080, 16'h0000, 16'h0845}, // R9 byte adc carry out bit 7
        '{4'd6,  3'd6, 1'b0, 16'hFF00, 16'h0000, 16'hFF00, 16'h0084}  // R6 parity low byte only
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  op = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [2:0]  ctl_set = '0;
    logic [2:0]  ctl_clr = '0;
    logic [15:0] result;
    logic [15:0] status;

    int errors = 0;
    int checks = 0;

    always #(CLK_NS/2) clk = ~clk;

    flag_alu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .op        (op),
        .byte_mode (byte_mode),
        .a         (a),
        .b         (b),
        .ctl_set   (ctl_set),
        .ctl_clr   (ctl_clr),
        .result    (result),
        .status    (status)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic bm, input logic [15:0] x, input logic [15:0] y);
        op = o; byte_mode = bm; a = x; b = y; en = 1'b1;
        @(negedge clk);
        en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "result after reset", result, 16'h0000);
        chk("R1", "status after reset", status, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i].op, TBL[i].bm, TBL[i].a, TBL[i].b);
            chk($sformatf("R%0d", TBL[i].req), $sformatf("vector %0d result", i), result, TBL[i].res);
            chk($sformatf("R%0d", TBL[i].req), $sformatf("vector %0d status", i), status, TBL[i].st);
        end

        // R11: disabled cycle with a live operation on the inputs
        op = 3'd0; a = 16'h0001; b = 16'h0001; byte_mode = 1'b0; en = 1'b0;
        @(negedge clk);
        chk("R11", "result held", result, 16'hFF00);
        chk("R11", "status held", status, 16'h0084);

        // R12: set DF alone
        ctl_set = 3'b100;
        @(negedge clk);
        ctl_set = '0;
        chk("R12", "DF set", status, 16'h0484);

        // R12: arithmetic leaves DF untouched
        run_op(3'd0, 1'b0, 16'h0001, 16'h0001);
        chk("R12", "add result", result, 16'h0002);
        chk("R12", "DF kept over add", status, 16'h0400);

        // R12: set beats clear on TF, clear on DF
        ctl_set = 3'b001; ctl_clr = 3'b101;
        @(negedge clk);
        ctl_set = '0; ctl_clr = '0;
        chk("R12", "set priority", status, 16'h0100);

        // R13: every used flag high, reserved bits still low
        ctl_set = 3'b111;
        run_op(3'd0, 1'b0, 16'h8000, 16'h8000);
        ctl_set = '0;
        chk("R13", "full status", status, 16'h0F45);
        chk("R13", "reserved bits", status & 16'hF02A, 16'h0000);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "result after late reset", result, 16'h0000);
        chk("R1", "status after late reset", status, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule